// File: doc/BRIEF.md
# Byte-Run Halfword Write Merger

This block takes a request to store a run of bytes, given as a start byte address and a 16-bit byte count, and turns it into a sequence of 16-bit writes to a memory that accepts only whole halfwords. Bytes arrive one at a time on a ready/valid byte source. Two bytes that share a halfword are packed and written together. A byte without a partner in the run is a lone byte. For a lone byte the block first reads the halfword that holds it, keeps the neighbouring byte from that read, and writes the merged halfword back. The memory therefore never needs byte enables.

A lone byte occurs at an odd start address, or as the final byte when one byte is left after the paired writes. The block raises `busy` while a transfer runs and pulses `done` once the last halfword has been accepted. Address decoding, the memory itself and any program or erase command sequencing belong to the surrounding system.

Top module: `hw_merge_writer`

## Requirements
- R1: A start with a byte count of zero issues no write, no read and takes no byte. `done` is high for the single cycle after the start and `busy` stays low.
- R2: When the start address is odd, the first write carries only the first byte, merged, and it comes before any paired write.
- R3: A lone byte at an odd address is placed in bits 15:8. Bits 7:0 are taken from bits 7:0 of the halfword read at that address with bit 0 cleared, which is the byte at the address minus one.
- R4: A lone byte at an even address is placed in bits 7:0. Bits 15:8 are taken from bits 15:8 of the halfword read at that address, which is the byte at the address plus one.
- R5: Paired bytes are packed little-endian: the earlier byte goes to bits 7:0 and the later byte to bits 15:8.
- R6: Every write and read address is the byte address with bit 0 cleared. Successive writes of one transfer use ascending halfword addresses.
- R7: When exactly one byte is left after the paired writes, it is written as a merged lone byte.
- R8: The remaining count is 16 bits wide. It drops by 2 for each paired write and by 1 for each lone write, so a transfer issues exactly one write per pair plus one per lone byte and takes exactly the requested number of source bytes.
- R9: A lone write is issued only after the neighbour read data is marked valid. Each lone byte causes exactly one single-cycle read request, and paired writes cause none.
- R10: `done` pulses for exactly one cycle, in the cycle after the final write handshake. `busy` is high from the cycle after an accepted start through that handshake, and a start seen while `busy` is high is ignored.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady.
- R12: After reset `busy`, `done`, `wr_valid`, `rd_req` and `src_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start request, taken only while idle |
| start_addr | input | ADDR_W | First byte address of the run |
| start_len | input | LEN_W | Number of bytes in the run |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| src_valid | input | 1 | Source byte available |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Block takes the source byte this cycle |
| rd_req | output | 1 | Neighbour read request, one cycle |
| rd_addr | output | ADDR_W | Neighbour read address, bit 0 zero |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 16 | Read halfword |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | ADDR_W | Write address, bit 0 zero |
| wr_data | output | 16 | Write halfword |

## Verification
Two events can fall in the same cycle: the handshake of the final halfword and a new `start` request, and a mid-transfer `start` together with ordinary byte or write traffic. The bench raises `start` in exactly the cycle where the last write is being accepted, and in another vector in the middle of a run with a different address. It judges both cases by the halfword count, by a full compare of memory against a byte-level model, and by `busy` staying low with no further writes afterwards. Source and write stalls are interleaved in several vectors so that held writes and waits for neighbour reads overlap with byte arrival.

// File: rtl/hmw_pkg.sv
// Package for the halfword merge writer: sequencing states shared by
// the controller and the checker.
package hmw_pkg;

    // Controller states; a lone byte visits RD_REQ and RD_WAIT, a pair BYTE1.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_BYTE0   = 3'd1,
        ST_BYTE1   = 3'd2,
        ST_RD_REQ  = 3'd3,
        ST_RD_WAIT = 3'd4,
        ST_WRITE   = 3'd5
    } hmw_state_t;

    localparam int unsigned HW_BYTES = 2;

endpackage

// File: rtl/hmw_tracker.sv
// Address and remaining-count tracker.
// Loads the run on start and advances by one lone byte or by one pair
// on each accepted write. It classifies the next write as lone (odd
// address, or a single byte left) and flags the last write.
// Assumes load and advance are never high in the same cycle.
module hmw_tracker #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              advance,
    output logic              lone,
    output logic              odd,
    output logic              last,
    output logic [ADDR_W-1:0] hw_addr
);

    localparam logic [LEN_W-1:0]  ONE_L  = LEN_W'(1);
    localparam logic [LEN_W-1:0]  TWO_L  = LEN_W'(2);
    localparam logic [ADDR_W-1:0] ONE_A  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO_A  = ADDR_W'(2);

    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  remain;
    logic [LEN_W-1:0]  step_len;
    logic [ADDR_W-1:0] step_addr;

    // Classify the pending write and size its step.
    always_comb begin
        odd       = cur_addr[0];
        lone      = cur_addr[0] || (remain == ONE_L);
        step_len  = lone ? ONE_L : TWO_L;
        step_addr = lone ? ONE_A : TWO_A;
        last      = (remain == step_len);
        hw_addr   = {cur_addr[ADDR_W-1:1], 1'b0};
    end

    // Hold the current byte address and the count still to write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
        end else if (load) begin
            cur_addr <= load_addr;
            remain   <= load_len;
        end else if (advance) begin
            cur_addr <= cur_addr + step_addr;
            remain   <= remain - step_len;
        end
    end

endmodule

// File: rtl/hmw_packer.sv
// Halfword packer.
// Captures the first and second source bytes and the neighbour halfword,
// and forms the write data lane by lane. For a pair, lane 0 takes the
// first byte and lane 1 the second. For a lone byte, the lane picked by
// address bit 0 takes the byte and the other lane keeps the neighbour.
// Assumes the capture strobes come one at a time from the controller.
module hmw_packer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap_first,
    input  logic        cap_second,
    input  logic        cap_nb,
    input  logic [7:0]  byte_in,
    input  logic [15:0] nb_in,
    input  logic        lone,
    input  logic        odd,
    output logic [15:0] word
);

    logic [7:0]  first_q;
    logic [7:0]  second_q;
    logic [15:0] nb_q;

    // Keep the source bytes of the write being built.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q  <= '0;
            second_q <= '0;
        end else begin
            if (cap_first)  first_q  <= byte_in;
            if (cap_second) second_q <= byte_in;
        end
    end

    // Keep the neighbour halfword returned by the read port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nb_q <= '0;
        else if (cap_nb)
            nb_q <= nb_in;
    end

    for (genvar ln = 0; ln < hmw_pkg::HW_BYTES; ln++) begin : g_lane
        localparam logic LANE_BIT = (ln != 0);
        // Select the byte driven onto this lane.
        always_comb begin
            if (!lone)
                word[8*ln +: 8] = (ln == 0) ? first_q : second_q;
            else if (odd == LANE_BIT)
                word[8*ln +: 8] = first_q;
            else
                word[8*ln +: 8] = nb_q[8*ln +: 8];
        end
    end

endmodule

// File: rtl/hmw_ctrl.sv
// Transfer sequencer.
// Walks each write through byte fetch, an optional neighbour read and
// the write handshake. It raises the capture and advance strobes for
// the packer and the tracker and makes the one-cycle done pulse.
// Assumes read data arrives with rd_valid some cycles after rd_req.
module hmw_ctrl
    import hmw_pkg::*;
#(
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] start_len,
    input  logic             src_valid,
    input  logic             rd_valid,
    input  logic             wr_ready,
    input  logic             lone,
    input  logic             last,
    output logic             busy,
    output logic             done,
    output logic             src_ready,
    output logic             rd_req,
    output logic             wr_valid,
    output logic             load,
    output logic             advance,
    output logic             cap_first,
    output logic             cap_second,
    output logic             cap_nb
);

    hmw_state_t state, state_nx;
    logic       zero_start;
    logic       finish;
    logic       done_q;

    // Decode per-state strobes from the current state and inputs.
    always_comb begin
        zero_start = (state == ST_IDLE) && start && (start_len == '0);
        load       = (state == ST_IDLE) && start && (start_len != '0);
        src_ready  = (state == ST_BYTE0) || (state == ST_BYTE1);
        cap_first  = (state == ST_BYTE0) && src_valid;
        cap_second = (state == ST_BYTE1) && src_valid;
        rd_req     = (state == ST_RD_REQ);
        cap_nb     = (state == ST_RD_WAIT) && rd_valid;
        wr_valid   = (state == ST_WRITE);
        advance    = (state == ST_WRITE) && wr_ready;
        finish     = advance && last;
        busy       = (state != ST_IDLE);
        done       = done_q;
    end

    // Choose the next sequencing step.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (load) state_nx = ST_BYTE0;
            ST_BYTE0:   if (src_valid) state_nx = lone ? ST_RD_REQ : ST_BYTE1;
            ST_BYTE1:   if (src_valid) state_nx = ST_WRITE;
            ST_RD_REQ:  state_nx = ST_RD_WAIT;
            ST_RD_WAIT: if (rd_valid) state_nx = ST_WRITE;
            ST_WRITE:   if (wr_ready) state_nx = last ? ST_IDLE : ST_BYTE0;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Register the sequencing state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Pulse done after the last write or after an empty request.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= finish || zero_start;
    end

endmodule

// File: rtl/hw_merge_writer.sv
// Byte-run to halfword write merger, top level.
// Joins the sequencer, the address/count tracker and the packer.
// Read and write addresses are the current byte address with bit 0
// cleared; the memory sees only whole-halfword writes.
// Assumes the memory keeps read data stable until rd_valid is seen.
module hw_merge_writer #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    output logic              busy,
    output logic              done,
    input  logic              src_valid,
    input  logic [7:0]        src_data,
    output logic              src_ready,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [15:0]       rd_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [15:0]       wr_data
);

    logic              lone, odd, last;
    logic              load, advance;
    logic              cap_first, cap_second, cap_nb;
    logic [ADDR_W-1:0] hw_addr;

    hmw_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_len  (start_len),
        .src_valid  (src_valid),
        .rd_valid   (rd_valid),
        .wr_ready   (wr_ready),
        .lone       (lone),
        .last       (last),
        .busy       (busy),
        .done       (done),
        .src_ready  (src_ready),
        .rd_req     (rd_req),
        .wr_valid   (wr_valid),
        .load       (load),
        .advance    (advance),
        .cap_first  (cap_first),
        .cap_second (cap_second),
        .cap_nb     (cap_nb)
    );

    hmw_tracker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_addr (start_addr),
        .load_len  (start_len),
        .advance   (advance),
        .lone      (lone),
        .odd       (odd),
        .last      (last),
        .hw_addr   (hw_addr)
    );

    hmw_packer u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_first  (cap_first),
        .cap_second (cap_second),
        .cap_nb     (cap_nb),
        .byte_in    (src_data),
        .nb_in      (rd_data),
        .lone       (lone),
        .odd        (odd),
        .word       (wr_data)
    );

    // Both memory ports address the halfword holding the current byte.
    always_comb begin
        rd_addr = hw_addr;
        wr_addr = hw_addr;
    end

endmodule

// File: rtl/hmw_checker.sv
// Protocol checker for hw_merge_writer, attached with bind.
// Watches only the ports of the top module.
module hmw_checker #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned LEN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LEN_W-1:0]  start_len,
    input logic              busy,
    input logic              done,
    input logic              src_ready,
    input logic              rd_req,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [15:0]       wr_data
);

    AST_ZERO_LEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && start_len == '0) |=> (done && !busy)); // R1

    AST_WR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !wr_addr[0]); // R6

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_valid && wr_ready) || $past(start && !busy))); // R10

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wr_valid && !src_ready && !rd_req)); // R12

endmodule

bind hw_merge_writer hmw_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_hmw_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_len (start_len),
    .busy      (busy),
    .done      (done),
    .src_ready (src_ready),
    .rd_req    (rd_req),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
);

// File: tb/hw_merge_writer_bench.sv
`timescale 1ns/1ps
module hw_merge_writer_bench;

    localparam int AW = 20;
    localparam int LW = 16;

    typedef struct packed {
        logic [8:0]  addr;
        logic [15:0] len;
        logic [15:0] exp_w;
        logic [15:0] exp_r;
        logic [7:0]  seed;
        logic        stall;
        logic        late;
        logic        mid;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{9'd0,   16'd4,   16'd2,   16'd0, 8'h10, 1'b0, 1'b0, 1'b0},
        '{9'd1,   16'd4,   16'd3,   16'd2, 8'h20, 1'b0, 1'b0, 1'b0},
        '{9'd1,   16'd1,   16'd1,   16'd1, 8'h30, 1'b0, 1'b0, 1'b0},
        '{9'd6,   16'd1,   16'd1,   16'd1, 8'h40, 1'b1, 1'b0, 1'b0},
        '{9'd2,   16'd3,   16'd2,   16'd1, 8'h50, 1'b0, 1'b0, 1'b0},
        '{9'd3,   16'd2,   16'd2,   16'd2, 8'h60, 1'b1, 1'b0, 1'b0},
        '{9'd5,   16'd7,   16'd4,   16'd1, 8'h70, 1'b0, 1'b0, 1'b1},
        '{9'd16,  16'd10,  16'd5,   16'd0, 8'h80, 1'b1, 1'b0, 1'b0},
        '{9'd33,  16'd300, 16'd151, 16'd2, 8'h90, 1'b1, 1'b0, 1'b0},
        '{9'd100, 16'd3,   16'd2,   16'd1, 8'hA0, 1'b0, 1'b1, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [LW-1:0] start_len = '0;
    logic          busy, done;
    logic          src_valid = 1'b0;
    logic [7:0]    src_data;
    logic          src_ready;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_valid = 1'b0;
    logic [15:0]   rd_data = '0;
    logic          wr_valid;
    logic          wr_ready = 1'b0;
    logic [AW-1:0] wr_addr;
    logic [15:0]   wr_data;

    logic [15:0] mem [256];
    logic [15:0] exp_mem [256];
    int          wcnt = 0;
    int          rcnt = 0;
    int          kbyte = 0;
    logic [7:0]  seed = '0;
    int          total = 0;
    int          bad = 0;

    always #2 clk = ~clk;

    hw_merge_writer #(.ADDR_W(AW), .LEN_W(LW)) u_hw_merge_writer (.*);

    assign src_data = seed + 8'(kbyte);

    // Memory and source responders.
    always @(posedge clk) begin
        if (wr_valid && wr_ready) begin
            mem[wr_addr[8:1]] <= wr_data;
            wcnt <= wcnt + 1;
        end
        rd_valid <= rd_req;
        if (rd_req) begin
            rd_data <= mem[rd_addr[8:1]];
            rcnt <= rcnt + 1;
        end
        if (src_valid && src_ready) kbyte <= kbyte + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic run_vec(input vec_t v, input string tag);
        int w0, r0, mism, cyc, b, wdone;
        bit seen;
        for (int j = 0; j < 256; j++) begin
            mem[j] = {8'(j * 7 + 3), ~8'(j)};
            exp_mem[j] = mem[j];
        end
        for (int i = 0; i < int'(v.len); i++) begin
            b = int'(v.addr) + i;
            if (b % 2 == 1) exp_mem[(b / 2) % 256][15:8] = v.seed + 8'(i);
            else            exp_mem[(b / 2) % 256][7:0]  = v.seed + 8'(i);
        end
        @(negedge clk);
        seed = v.seed;
        kbyte = 0;
        w0 = wcnt;
        r0 = rcnt;
        start_addr = AW'(v.addr);
        start_len = v.len;
        start = 1'b1;
        src_valid = 1'b1;
        wr_ready = 1'b1;
        seen = 0;
        cyc = 0;
        while (!seen && cyc < 6000) begin
            @(negedge clk);
            cyc++;
            if (done) seen = 1;
            src_valid = v.stall ? (cyc % 3 != 0) : 1'b1;
            wr_ready  = v.stall ? (cyc % 4 != 1) : 1'b1;
            start = 1'b0;
            if (v.mid && cyc == 4) begin
                start = 1'b1;
                start_addr = AW'(200);
                start_len = 16'd4;
            end
            if (v.late && wr_valid && wr_ready && (wcnt - w0) == int'(v.exp_w) - 1) begin
                start = 1'b1;
                start_addr = AW'(300);
                start_len = 16'd2;
            end
        end
        start = 1'b0;
        check(seen, {tag, " R10 done seen"}, int'(seen), 1);
        @(negedge clk);
        check(!done, {tag, " R10 done single"}, int'(done), 0);
        for (int k = 0; k < 8; k++) @(negedge clk);
        check(!busy, {tag, " R10 idle after"}, int'(busy), 0);
        wdone = wcnt - w0;
        check(wdone == int'(v.exp_w), {tag, " R8 write count"}, wdone, int'(v.exp_w));
        check(rcnt - r0 == int'(v.exp_r), {tag, " R9 read count"}, rcnt - r0, int'(v.exp_r));
        check(kbyte == int'(v.len), {tag, " R8 bytes taken"}, kbyte, int'(v.len));
        mism = 0;
        for (int j = 0; j < 256; j++) if (mem[j] !== exp_mem[j]) mism++;
        check(mism == 0, {tag, " R6 memory image"}, mism, 0);
    endtask

    initial begin : watchdog
        #1000000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int w0, r0;
        repeat (3) @(negedge clk);
        // R12: reset state
        check(!busy && !done, "R12 busy/done in reset", int'(busy) + int'(done), 0);
        check(!wr_valid && !rd_req && !src_ready, "R12 ports quiet in reset",
              int'(wr_valid) + int'(rd_req) + int'(src_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R12 idle after reset", int'(busy) + int'(done), 0);

        // R1: zero-length request
        w0 = wcnt;
        r0 = rcnt;
        start_addr = AW'(7);
        start_len = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done && !busy, "R1 done next cycle, not busy", int'(done) * 2 + int'(busy), 2);
        @(negedge clk);
        check(!done, "R1 done one cycle", int'(done), 0);
        repeat (4) @(negedge clk);
        check(wcnt == w0 && rcnt == r0, "R1 no memory traffic", (wcnt - w0) + (rcnt - r0), 0);

        // Table: R5 pairs, R2/R3 odd start, R4 even lone, R7 trailing, R8 long run,
        // R10/R11 stalls, mid-run start and start at the last handshake.
        run_vec(VECS[0], "v0 R5 pairs");
        run_vec(VECS[1], "v1 R2 R3 R7");
        run_vec(VECS[2], "v2 R3 single odd");
        run_vec(VECS[3], "v3 R4 single even");
        run_vec(VECS[4], "v4 R7 R4 trailing");
        run_vec(VECS[5], "v5 R2 R3 R4 two lones");
        run_vec(VECS[6], "v6 R10 mid start ignored");
        run_vec(VECS[7], "v7 R11 stalls");
        run_vec(VECS[8], "v8 R8 long run");
        run_vec(VECS[9], "v9 R10 start at last handshake");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule